// File: doc/BRIEF.md
# ADC Conversion Timing Sequencer

This block is the digital side of a multi-channel successive-approximation converter. Software programs a prescaler, a power-up wait and a sample-and-hold length through a small word-addressed register bus. It selects channels and then issues a start. The sequencer derives a slow ADC clock enable from the system clock, waits for the converter to power up, and holds the sample phase before each channel. It then pulses a start towards the converter. Each result returned is stored.

Every result goes into that channel's data word and into a shared most-recent-result word, and a data-ready flag is raised. The interrupt line follows that flag through an enable bit. Reading the most-recent word acknowledges the flag. A low-resolution bit narrows the stored results. A sleep bit lets the converter power down after every sequence, so that the power-up wait is paid again on the next one. A hardware trigger input can start sequences in place of the software start bit.

Top module: `adcs_top`

## Requirements
- R1: The ADC clock enable fires once every (PRS+1)*2 system clocks, where PRS is the prescale field MODE[5:0] (MODE at word address 1).
- R2: When the converter is powered down, the first start pulse of a sequence rises exactly ((STU+1)*8 + (SHT+1)) ADC periods after the edge that accepts the start. STU is MODE[11:8] and SHT is MODE[19:16].
- R3: Every channel after the first in a sequence gets only the sample phase. Its start pulse rises (SHT+1) ADC periods after the edge on which the previous result was taken, and each start pulse lasts one cycle.
- R4: Writing 1 to bit 0 of CTRL (word address 0) converts each channel enabled at that moment exactly once, in ascending index order. The index is driven on cv_chan.
- R5: A start is ignored while a sequence runs and when no channel is enabled. STATUS (address 8) bit 1 reads 1 while a sequence runs.
- R6: Writing a 1 to a bit of CH_SET (address 2) enables that channel, and writing a 1 to a bit of CH_CLR (address 3) disables it. Zero bits leave channels unchanged. CH_MASK (address 4) reads the enable bits.
- R7: Each result is written to the channel data word (address 16+index) and to LAST (address 9). STATUS bit 0 (data ready) is then set.
- R8: Reading LAST clears data ready, unless a result arrives in the same cycle.
- R9: irq equals data ready AND the interrupt enable bit. Bit 0 of IE_SET (address 5) sets the enable bit, bit 0 of IE_CLR (address 6) clears it, and IE_MASK (address 7) reads it.
- R10: With MODE[24] set, a stored result keeps only the low 8 bits of cv_result, zero-extended, and cv_lowres is 1.
- R11: With MODE[25] clear, the converter stays powered after its first power-up, so later sequences skip the power-up wait. With MODE[25] set, it powers down when a sequence ends (cv_pwr falls) and the wait is repeated.
- R12: Writing 1 to CTRL bit 1 returns every register, all channel data and the sequencer to their reset values.
- R13: A one-cycle pulse on hw_trig starts a sequence only when MODE[26] is set. Otherwise it has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_wr | input | 1 | Register write strobe |
| bus_rd | input | 1 | Register read strobe |
| bus_addr | input | 5 | Word address |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, valid the cycle after bus_rd |
| hw_trig | input | 1 | Hardware start pulse |
| irq | output | 1 | Interrupt request |
| cv_pwr | output | 1 | Converter power enable |
| cv_lowres | output | 1 | Converter low-resolution select |
| cv_start | output | 1 | Conversion start pulse |
| cv_chan | output | 2 | Channel being converted |
| cv_done | input | 1 | Conversion complete pulse |
| cv_result | input | 10 | Conversion result |

## Verification
On every cycle, the assertions check three things: the spacing of the ADC clock enable, the one-cycle start pulse, and that the pending channel set only ever shrinks during a sequence. They also check that a busy sequencer ignores starts, that data ready rises only from a stored result and falls on a LAST read, and that a soft reset clears state. Only the bench scenarios show exact phase lengths for several prescaler and timing settings, the ascending channel order, and the skipped or repeated power-up wait in each sleep setting. The same holds for narrowed results and for trigger gating. The bench also compares irq against a behavioural model on every clock.

// File: rtl/adcs_pkg.sv
package adcs_pkg;
  typedef enum logic [1:0] {SQ_IDLE, SQ_WAKE, SQ_SAMPLE, SQ_CONV} sq_state_e;

  // word addresses
  localparam int A_CTRL  = 0;
  localparam int A_MODE  = 1;
  localparam int A_CHSET = 2;
  localparam int A_CHCLR = 3;
  localparam int A_CHMSK = 4;
  localparam int A_IESET = 5;
  localparam int A_IECLR = 6;
  localparam int A_IEMSK = 7;
  localparam int A_STAT  = 8;
  localparam int A_LAST  = 9;
  localparam int A_DATA  = 16;

  // control bits
  localparam int CTL_START = 0;
  localparam int CTL_SWRST = 1;

  // mode field positions
  localparam int F_PRS    = 0;
  localparam int F_STU    = 8;
  localparam int F_SHT    = 16;
  localparam int F_LOWRES = 24;
  localparam int F_SLEEP  = 25;
  localparam int F_TRGEN  = 26;
endpackage

// File: rtl/adcs_clkdiv.sv
module adcs_clkdiv #(
  parameter int PRS_W = 6
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             en,
  input  logic [PRS_W-1:0] prs,
  output logic             tick
);
  localparam int CW = PRS_W + 1;

  logic [CW-1:0] cnt_q;
  logic [CW-1:0] lim;

  assign lim  = {prs, 1'b1};        // (prs+1)*2 - 1
  assign tick = en && (cnt_q == lim);

  always_ff @(posedge clk) begin
    if (rst || !en) cnt_q <= '0;
    else if (cnt_q == lim) cnt_q <= '0;
    else cnt_q <= cnt_q + 1'b1;
  end

  // R1
  tick_gap_chk: assert property (@(posedge clk) disable iff (rst) tick |=> !tick);
endmodule

// File: rtl/adcs_fsm.sv
module adcs_fsm import adcs_pkg::*; #(
  parameter int NUM_CH = 4,
  parameter int STU_W  = 4,
  parameter int SHT_W  = 4,
  parameter int CH_W   = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              go,
  input  logic [NUM_CH-1:0] ch_en,
  input  logic [STU_W-1:0]  stu,
  input  logic [SHT_W-1:0]  sht,
  input  logic              sleep,
  input  logic              tick,
  input  logic              cv_done,
  output logic              run,
  output logic              cv_start,
  output logic [CH_W-1:0]   cv_chan,
  output logic              done_we,
  output logic              busy,
  output logic              cv_pwr
);
  localparam int TC_W = (STU_W + 3 > SHT_W) ? STU_W + 3 : SHT_W;

  sq_state_e         state_q;
  logic [NUM_CH-1:0] pend_q;
  logic [CH_W-1:0]   cur_q;
  logic [TC_W-1:0]   tcnt_q;
  logic              awake_q;
  logic              start_q;
  logic [NUM_CH-1:0] rest;
  logic [TC_W-1:0]   wake_last;
  logic [TC_W-1:0]   samp_last;

  function automatic logic [CH_W-1:0] first_set(input logic [NUM_CH-1:0] v);
    first_set = '0;
    for (int i = NUM_CH - 1; i >= 0; i--)
      if (v[i]) first_set = CH_W'(i);
  endfunction

  assign rest      = pend_q & ~(NUM_CH'(1) << cur_q);
  assign wake_last = TC_W'({stu, 3'b111});
  assign samp_last = TC_W'(sht);

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q <= SQ_IDLE;
      pend_q  <= '0;
      cur_q   <= '0;
      tcnt_q  <= '0;
      awake_q <= 1'b0;
      start_q <= 1'b0;
    end else begin
      start_q <= 1'b0;
      case (state_q)
        SQ_IDLE: if (go && (|ch_en)) begin
          pend_q  <= ch_en;
          cur_q   <= first_set(ch_en);
          tcnt_q  <= '0;
          state_q <= awake_q ? SQ_SAMPLE : SQ_WAKE;
        end
        SQ_WAKE: if (tick) begin
          if (tcnt_q == wake_last) begin
            tcnt_q  <= '0;
            awake_q <= 1'b1;
            state_q <= SQ_SAMPLE;
          end else tcnt_q <= tcnt_q + 1'b1;
        end
        SQ_SAMPLE: if (tick) begin
          if (tcnt_q == samp_last) begin
            tcnt_q  <= '0;
            start_q <= 1'b1;
            state_q <= SQ_CONV;
          end else tcnt_q <= tcnt_q + 1'b1;
        end
        SQ_CONV: if (cv_done) begin
          pend_q <= rest;
          if (|rest) begin
            cur_q   <= first_set(rest);
            state_q <= SQ_SAMPLE;
          end else begin
            state_q <= SQ_IDLE;
            if (sleep) awake_q <= 1'b0;
          end
        end
        default: state_q <= SQ_IDLE;
      endcase
    end
  end

  assign run      = (state_q == SQ_WAKE) || (state_q == SQ_SAMPLE);
  assign cv_start = start_q;
  assign cv_chan  = cur_q;
  assign done_we  = (state_q == SQ_CONV) && cv_done;
  assign busy     = (state_q != SQ_IDLE);
  assign cv_pwr   = awake_q || (state_q != SQ_IDLE);

  // R4
  pend_shrink_chk: assert property (@(posedge clk) disable iff (rst)
    (state_q != SQ_IDLE) |=> ((pend_q & ~$past(pend_q)) == '0));
  // R4
  start_pending_chk: assert property (@(posedge clk) disable iff (rst)
    cv_start |-> pend_q[cur_q]);
  // R3
  start_pulse_chk: assert property (@(posedge clk) disable iff (rst)
    cv_start |=> !cv_start);
  // R5
  busy_ignore_chk: assert property (@(posedge clk) disable iff (rst)
    (busy && go && !cv_done) |=> $stable(pend_q));
endmodule

// File: rtl/adcs_store.sv
module adcs_store #(
  parameter int NUM_CH = 4,
  parameter int RES_W  = 10,
  parameter int CH_W   = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             we,
  input  logic [CH_W-1:0]  waddr,
  input  logic [RES_W-1:0] wdata,
  input  logic [CH_W-1:0]  raddr,
  output logic [RES_W-1:0] rdata
);
  logic [RES_W-1:0] mem_q [NUM_CH];

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < NUM_CH; i++) mem_q[i] <= '0;
      rdata <= '0;
    end else begin
      if (we) mem_q[waddr] <= wdata;
      rdata <= mem_q[raddr];
    end
  end
endmodule

// File: rtl/adcs_top.sv
module adcs_top import adcs_pkg::*; #(
  parameter int NUM_CH = 4,
  parameter int RES_W  = 10,
  parameter int RES_LO = 8,
  parameter int PRS_W  = 6,
  parameter int STU_W  = 4,
  parameter int SHT_W  = 4,
  parameter int ADDR_W = 5,
  parameter int DW     = 32
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                bus_wr,
  input  logic                bus_rd,
  input  logic [ADDR_W-1:0]   bus_addr,
  input  logic [DW-1:0]       bus_wdata,
  output logic [DW-1:0]       bus_rdata,
  input  logic                hw_trig,
  output logic                irq,
  output logic                cv_pwr,
  output logic                cv_lowres,
  output logic                cv_start,
  output logic [((NUM_CH > 1) ? $clog2(NUM_CH) : 1)-1:0] cv_chan,
  input  logic                cv_done,
  input  logic [RES_W-1:0]    cv_result
);
  localparam int CH_W = (NUM_CH > 1) ? $clog2(NUM_CH) : 1;

  logic              wr_ctrl, swr, rst_i, go, rd_last, tick, run, done_we, busy;
  logic [PRS_W-1:0]  prs_q;
  logic [STU_W-1:0]  stu_q;
  logic [SHT_W-1:0]  sht_q;
  logic              lowres_q, sleep_q, trgen_q, ie_q, drdy_q;
  logic [NUM_CH-1:0] ch_en_q;
  logic [RES_W-1:0]  last_q, res_eff, store_q;
  logic [DW-1:0]     mode_word, rd_q;
  logic              sel_mem_q, in_rng;
  logic [ADDR_W-1:0] data_idx;
  logic              unused_bits;

  assign wr_ctrl = bus_wr && (bus_addr == ADDR_W'(A_CTRL));
  assign swr     = wr_ctrl && bus_wdata[CTL_SWRST];
  assign rst_i   = rst || swr;
  assign go      = (wr_ctrl && bus_wdata[CTL_START]) || (trgen_q && hw_trig);
  assign rd_last = bus_rd && (bus_addr == ADDR_W'(A_LAST));
  assign res_eff = lowres_q ? RES_W'(cv_result[RES_LO-1:0]) : cv_result;
  assign data_idx = bus_addr - ADDR_W'(A_DATA);
  assign in_rng  = (bus_addr >= ADDR_W'(A_DATA)) && (data_idx < ADDR_W'(NUM_CH));
  assign unused_bits = ^bus_wdata;

  adcs_clkdiv #(.PRS_W(PRS_W)) u_div (
    .clk(clk), .rst(rst_i), .en(run), .prs(prs_q), .tick(tick));

  adcs_fsm #(.NUM_CH(NUM_CH), .STU_W(STU_W), .SHT_W(SHT_W), .CH_W(CH_W)) u_fsm (
    .clk(clk), .rst(rst_i), .go(go), .ch_en(ch_en_q), .stu(stu_q), .sht(sht_q),
    .sleep(sleep_q), .tick(tick), .cv_done(cv_done), .run(run),
    .cv_start(cv_start), .cv_chan(cv_chan), .done_we(done_we), .busy(busy),
    .cv_pwr(cv_pwr));

  adcs_store #(.NUM_CH(NUM_CH), .RES_W(RES_W), .CH_W(CH_W)) u_store (
    .clk(clk), .rst(rst_i), .we(done_we), .waddr(cv_chan), .wdata(res_eff),
    .raddr(data_idx[CH_W-1:0]), .rdata(store_q));

  always_ff @(posedge clk) begin
    if (rst_i) begin
      prs_q <= '0; stu_q <= '0; sht_q <= '0;
      lowres_q <= 1'b0; sleep_q <= 1'b0; trgen_q <= 1'b0;
      ch_en_q <= '0; ie_q <= 1'b0; drdy_q <= 1'b0; last_q <= '0;
    end else begin
      if (bus_wr) begin
        case (bus_addr)
          ADDR_W'(A_MODE): begin
            prs_q    <= bus_wdata[F_PRS +: PRS_W];
            stu_q    <= bus_wdata[F_STU +: STU_W];
            sht_q    <= bus_wdata[F_SHT +: SHT_W];
            lowres_q <= bus_wdata[F_LOWRES];
            sleep_q  <= bus_wdata[F_SLEEP];
            trgen_q  <= bus_wdata[F_TRGEN];
          end
          ADDR_W'(A_CHSET): ch_en_q <= ch_en_q | bus_wdata[NUM_CH-1:0];
          ADDR_W'(A_CHCLR): ch_en_q <= ch_en_q & ~bus_wdata[NUM_CH-1:0];
          ADDR_W'(A_IESET): if (bus_wdata[0]) ie_q <= 1'b1;
          ADDR_W'(A_IECLR): if (bus_wdata[0]) ie_q <= 1'b0;
          default: ;
        endcase
      end
      if (rd_last) drdy_q <= 1'b0;
      if (done_we) begin
        drdy_q <= 1'b1;
        last_q <= res_eff;
      end
    end
  end

  always_comb begin
    mode_word = '0;
    mode_word[F_PRS +: PRS_W] = prs_q;
    mode_word[F_STU +: STU_W] = stu_q;
    mode_word[F_SHT +: SHT_W] = sht_q;
    mode_word[F_LOWRES] = lowres_q;
    mode_word[F_SLEEP]  = sleep_q;
    mode_word[F_TRGEN]  = trgen_q;
  end

  always_ff @(posedge clk) begin
    if (rst_i) begin
      rd_q <= '0;
      sel_mem_q <= 1'b0;
    end else if (bus_rd) begin
      sel_mem_q <= in_rng;
      case (bus_addr)
        ADDR_W'(A_MODE):  rd_q <= mode_word;
        ADDR_W'(A_CHMSK): rd_q <= DW'(ch_en_q);
        ADDR_W'(A_IEMSK): rd_q <= DW'(ie_q);
        ADDR_W'(A_STAT):  rd_q <= DW'({busy, drdy_q});
        ADDR_W'(A_LAST):  rd_q <= DW'(last_q);
        default:          rd_q <= '0;
      endcase
    end
  end

  assign bus_rdata = sel_mem_q ? DW'(store_q) : rd_q;
  assign irq       = drdy_q && ie_q;
  assign cv_lowres = lowres_q;

  // R8
  rd_clear_chk: assert property (@(posedge clk) disable iff (rst_i)
    (rd_last && !done_we) |=> !drdy_q);
  // R7
  drdy_src_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(drdy_q) |-> $past(done_we));
  // R12
  swreset_chk: assert property (@(posedge clk) disable iff (rst)
    swr |=> (ch_en_q == '0 && !drdy_q && !ie_q && !busy && !cv_pwr));
  // R6
  chset_keep_chk: assert property (@(posedge clk) disable iff (rst_i)
    (bus_wr && bus_addr == ADDR_W'(A_CHSET)) |=> ((ch_en_q & $past(ch_en_q)) == $past(ch_en_q)));
endmodule

// File: tb/adcs_top_bench.sv
`timescale 1ns/1ps
module adcs_top_bench;
  import adcs_pkg::*;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        bus_wr = 1'b0, bus_rd = 1'b0;
  logic [4:0]  bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic        hw_trig = 1'b0;
  logic        irq, cv_pwr, cv_lowres, cv_start;
  logic [1:0]  cv_chan;
  logic        cv_done = 1'b0;
  logic [9:0]  cv_result = '0;

  int tests = 0, fails = 0, irq_tests = 0, irq_fails = 0;
  int cyc = 0;
  bit finished = 0;

  int st_cyc[$];
  int st_ch[$];
  int dn_cyc[$];
  int lat_cnt = 0;
  int cur_ch = 0;
  bit m_drdy = 0, m_mask = 0;

  always #10 clk = ~clk;

  adcs_top u_adcs_top (
    .clk(clk), .rst(rst), .bus_wr(bus_wr), .bus_rd(bus_rd), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .hw_trig(hw_trig), .irq(irq),
    .cv_pwr(cv_pwr), .cv_lowres(cv_lowres), .cv_start(cv_start), .cv_chan(cv_chan),
    .cv_done(cv_done), .cv_result(cv_result));

  function automatic logic [9:0] mkres(input int ch);
    return 10'(32'h2B4 + ch * 81);
  endfunction

  function automatic logic [31:0] mode_w(input int prs, input int stu, input int sht,
                                         input int lr, input int slp, input int trg);
    return 32'(prs | (stu << 8) | (sht << 16) | (lr << 24) | (slp << 25) | (trg << 26));
  endfunction

  // behavioural converter
  always @(negedge clk) begin
    cv_done = 1'b0;
    if (lat_cnt == 1) begin
      cv_done = 1'b1;
      cv_result = mkres(cur_ch);
      dn_cyc.push_back(cyc);
    end
    if (lat_cnt > 0) lat_cnt--;
    if (cv_start) begin
      st_cyc.push_back(cyc);
      st_ch.push_back(int'(cv_chan));
      cur_ch = int'(cv_chan);
      lat_cnt = 3;
    end
  end

  // reference model for data ready and interrupt enable, updated per clock
  always @(posedge clk) begin
    cyc++;
    if (rst || (bus_wr && bus_addr == 5'(A_CTRL) && bus_wdata[1])) begin
      m_drdy = 0; m_mask = 0;
    end else begin
      if (bus_wr && bus_addr == 5'(A_IESET) && bus_wdata[0]) m_mask = 1;
      if (bus_wr && bus_addr == 5'(A_IECLR) && bus_wdata[0]) m_mask = 0;
      if (bus_rd && bus_addr == 5'(A_LAST)) m_drdy = 0;
      if (cv_done) m_drdy = 1;
    end
  end

  always @(negedge clk) begin
    if (!rst) begin
      irq_tests++;
      if (irq !== (m_drdy & m_mask)) begin
        irq_fails++;
        $display("FAIL R9 irq per-cycle: actual %0b expected %0b", irq, m_drdy & m_mask);
      end
    end
  end

  task automatic chk(input string tag, input int act, input int exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic wr(input int a, input logic [31:0] d);
    bus_wr = 1'b1; bus_addr = 5'(a); bus_wdata = d;
    @(negedge clk);
    bus_wr = 1'b0; bus_wdata = '0;
  endtask

  task automatic rd(input int a, output logic [31:0] d);
    bus_rd = 1'b1; bus_addr = 5'(a);
    @(negedge clk);
    d = bus_rdata;
    bus_rd = 1'b0;
  endtask

  task automatic wait_idle();
    logic [31:0] v;
    for (int i = 0; i < 3000; i++) begin
      rd(A_STAT, v);
      if (v[1] == 1'b0) break;
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      $display("FAIL watchdog: actual timeout expected completion");
      $display("[TB] %0d tests run, %0d failed", tests + irq_tests + 1, fails + irq_fails + 1);
      $finish;
    end
  end

  initial begin
    logic [31:0] v;
    int n0, w0;
    repeat (5) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);

    // reset state (R12)
    rd(A_STAT, v);  chk("R12 reset status", int'(v), 0);
    rd(A_CHMSK, v); chk("R12 reset channel mask", int'(v), 0);
    rd(A_MODE, v);  chk("R12 reset mode", int'(v), 0);
    chk("R12 reset cv_pwr", int'(cv_pwr), 0);
    chk("R12 reset cv_start", int'(cv_start), 0);

    // R6 write-one enable/disable
    wr(A_CHSET, 32'h5);
    rd(A_CHMSK, v); chk("R6 set 0101", int'(v), 5);
    wr(A_CHSET, 32'h2);
    rd(A_CHMSK, v); chk("R6 zero bits keep", int'(v), 7);
    wr(A_CHCLR, 32'h4);
    rd(A_CHMSK, v); chk("R6 clear bit2", int'(v), 3);
    wr(A_CHCLR, 32'h0);
    rd(A_CHMSK, v); chk("R6 clear zeros no effect", int'(v), 3);
    wr(A_IESET, 32'h1);
    rd(A_IEMSK, v); chk("R9 enable readback", int'(v), 1);

    // sequence over channels 1 and 3: D=4, startup 8, sample 2
    wr(A_MODE, mode_w(1, 0, 1, 0, 0, 0));
    wr(A_CHCLR, 32'hF);
    wr(A_CHSET, 32'hA);
    n0 = st_cyc.size();
    w0 = cyc;
    wr(A_CTRL, 32'h1);
    rd(A_STAT, v); chk("R5 busy bit", int'(v[1]), 1);
    wr(A_CTRL, 32'h1);              // ignored while busy
    wait_idle();
    chk("R5 restart ignored", st_cyc.size() - n0, 2);
    if (st_cyc.size() - n0 == 2) begin
      chk("R4 first channel", st_ch[n0], 1);
      chk("R4 second channel", st_ch[n0+1], 3);
      chk("R1/R2 power-up plus sample", st_cyc[n0] - w0 - 1, 40);
      chk("R3 sample only between channels", st_cyc[n0+1] - dn_cyc[n0] - 1, 8);
    end
    rd(A_DATA + 1, v); chk("R7 channel1 data", int'(v), int'(mkres(1)));
    rd(A_DATA + 3, v); chk("R7 channel3 data", int'(v), int'(mkres(3)));
    rd(A_DATA + 0, v); chk("R4 disabled channel untouched", int'(v), 0);
    rd(A_STAT, v); chk("R7 data ready set", int'(v[0]), 1);
    chk("R9 irq raised", int'(irq), 1);
    rd(A_LAST, v); chk("R7 last data", int'(v), int'(mkres(3)));
    rd(A_STAT, v); chk("R8 read clears ready", int'(v[0]), 0);
    chk("R9 irq dropped", int'(irq), 0);

    // R11 stays powered without sleep
    chk("R11 powered while idle", int'(cv_pwr), 1);
    n0 = st_cyc.size();
    w0 = cyc;
    wr(A_CTRL, 32'h1);
    wait_idle();
    if (st_cyc.size() > n0) chk("R11 no power-up wait", st_cyc[n0] - w0 - 1, 8);
    else chk("R11 sequence started", 0, 1);

    // sleep + low resolution, D=6, startup 16, sample 1
    wr(A_MODE, mode_w(2, 1, 0, 1, 1, 0));
    wr(A_CHCLR, 32'hF);
    wr(A_CHSET, 32'h4);
    n0 = st_cyc.size();
    w0 = cyc;
    wr(A_CTRL, 32'h1);
    wait_idle();
    if (st_cyc.size() > n0) chk("R1/R11 awake sample only", st_cyc[n0] - w0 - 1, 6);
    else chk("R11 sequence started", 0, 1);
    chk("R11 powered down after sleep", int'(cv_pwr), 0);
    n0 = st_cyc.size();
    w0 = cyc;
    wr(A_CTRL, 32'h1);
    wait_idle();
    if (st_cyc.size() > n0) chk("R2/R11 power-up repeated", st_cyc[n0] - w0 - 1, 102);
    else chk("R11 sequence started", 0, 1);
    rd(A_DATA + 2, v); chk("R10 narrowed data", int'(v), int'(mkres(2)) & 8'hFF);
    chk("R10 lowres output", int'(cv_lowres), 1);
    wr(A_IECLR, 32'h1);
    chk("R9 masked irq", int'(irq), 0);
    wr(A_IESET, 32'h1);
    chk("R9 unmasked irq", int'(irq), 1);
    rd(A_LAST, v); chk("R10 narrowed last", int'(v), int'(mkres(2)) & 8'hFF);

    // R5 no channels enabled
    wr(A_CHCLR, 32'hF);
    n0 = st_cyc.size();
    wr(A_CTRL, 32'h1);
    repeat (30) @(negedge clk);
    chk("R5 empty start ignored", st_cyc.size() - n0, 0);
    rd(A_STAT, v); chk("R5 empty start not busy", int'(v[1]), 0);

    // R13 hardware trigger gating
    wr(A_CHSET, 32'h1);
    n0 = st_cyc.size();
    hw_trig = 1'b1; @(negedge clk); hw_trig = 1'b0;
    repeat (150) @(negedge clk);
    chk("R13 trigger ignored when disabled", st_cyc.size() - n0, 0);
    wr(A_MODE, mode_w(2, 1, 0, 1, 1, 1));
    hw_trig = 1'b1; @(negedge clk); hw_trig = 1'b0;
    wait_idle();
    chk("R13 trigger starts sequence", st_cyc.size() - n0, 1);
    if (st_cyc.size() > n0) chk("R13 triggered channel", st_ch[n0], 0);

    // R12 software reset
    wr(A_CTRL, 32'h2);
    rd(A_MODE, v);  chk("R12 mode cleared", int'(v), 0);
    rd(A_CHMSK, v); chk("R12 channels cleared", int'(v), 0);
    rd(A_IEMSK, v); chk("R12 irq enable cleared", int'(v), 0);
    rd(A_STAT, v);  chk("R12 status cleared", int'(v), 0);
    rd(A_DATA + 0, v); chk("R12 channel0 data cleared", int'(v), 0);
    rd(A_DATA + 2, v); chk("R12 channel2 data cleared", int'(v), 0);
    chk("R12 converter powered down", int'(cv_pwr), 0);

    repeat (3) @(negedge clk);
    finished = 1;
    $display("[TB] %0d tests run, %0d failed", tests + irq_tests, fails + irq_fails);
    $finish;
  end
endmodule